// File: doc/BRIEF.md
# Flash embedded-operation status unit

This block is the status side of a NOR-style flash device. It follows embedded program and erase operations, which are modelled here only as start and finish pulses. It drives an active-low ready/busy pin and holds an 8-bit status register. While an operation runs, or while a failure is held, every array read returns a data-polling word in place of array data. Command writes arrive on an 8-bit code port. The array itself is a stub: in the idle state a read returns a fixed parameter word XOR the read address.

Two failure paths behave differently. A failed program, a failed erase or a write-buffer abort puts the unit into an error state. That state holds until software writes a clear or a reset command. A write aimed at a protected region works another way. The unit stays busy for a fixed window of `PROT_CYCLES` clocks with the status marked not-valid, and then recovers without help. In both the error state and the protection window, only three commands are honoured: status read, status clear and reset.

Top module: `flsr_status_unit`

## Requirements
- R1: After reset, `ready_nbusy` is 1 and `rd_valid` is 0. In the idle state a read returns `STUB_WORD ^ rd_addr` one cycle later, and a status read returns 0x0080.
- R2: `op_start` in the idle state captures `op_is_erase` and `wb_last_bit7`, then drives `ready_nbusy` low. `op_done` in the busy state drives it high again. `op_start` is ignored in every other state.
- R3: The polling word returned by any read while not idle is laid out as follows. Bits 15:8, 4 and 0 are 0. Bits 6 and 2 are equal and toggle on each polling read, starting at 0 after reset. Bit 3 is 1 for an erase operation. Bit 7 is 0 for an erase and the inverse of `wb_last_bit7` for a program. Bit 5 is 1 only in the error state. Bit 1 is 1 only in the error state when the abort flag is set.
- R4: In the busy state, `ev_prog_fail` sets status bit 4, `ev_erase_fail` sets bit 5 and `ev_wb_abort` sets bit 3. Each of them enters the error state, where `ready_nbusy` stays low.
- R5: The error state persists until command 0x71 (clear) or 0xF0 (reset) is written.
- R6: In the error state and in the protection window, every command code other than 0x70, 0x71 and 0xF0 is ignored (suspend 0xB0 among them).
- R7: `ev_protect` in the busy state sets status bit 1 and holds the unit busy for exactly `PROT_CYCLES` cycles. Polling bit 5 reads 0 during that window. The unit then returns to idle with `ready_nbusy` high.
- R8: A status read during the protection window returns bit 7 = 0. Bits 6:1 are not meaningful there.
- R9: After command 0x70, the next read at any address returns {0x00, status} and later reads revert to array or polling data. Status layout: bit 7 is valid (1 in idle and error, 0 in busy and protection), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 abort, bit 2 program suspended, bit 1 protected, bit 0 reads 0.
- R10: Command 0x71 zeroes status bits 5:1 and moves the error state to idle. It does not shorten a protection window.
- R11: Command 0xF0 zeroes status bits 6:1, cancels a pending status read, restarts the polling toggle at 0 and moves the busy or error state to idle. It leaves a protection window running.
- R12: In the busy state, command 0xB0 sets bit 6 for an erase or bit 2 for a program, and 0x30 clears both. `op_done` also clears both.
- R13: If events arrive in the same cycle, a failure event wins over `ev_protect`, which wins over `op_done`. Events outside the busy state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DW | Read data: array stub, polling word or status |
| op_start | input | 1 | Embedded operation starts |
| op_is_erase | input | 1 | Started operation is an erase |
| wb_last_bit7 | input | 1 | Bit 7 of the last word loaded into the write buffer |
| op_done | input | 1 | Embedded operation finished cleanly |
| ev_prog_fail | input | 1 | Program failure pulse |
| ev_erase_fail | input | 1 | Erase failure pulse |
| ev_protect | input | 1 | Protected-region write pulse |
| ev_wb_abort | input | 1 | Write-buffer abort pulse |
| ready_nbusy | output | 1 | High when ready, low when busy or in error |

## Verification
The properties assume that event pulses and command strobes are synchronous, single-cycle and free of X, and that `rd_en` is a clean strobe. The stimulus changes these inputs only at falling edges and drops every pulse after one cycle. The window check assumes `PROT_CYCLES` is at least 1. The bench runs the unit with a short window of 40 cycles so that every path through the window, clear and reset commands inside it included, fits within the run.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_PROT = 2'd2,
    ST_ERR  = 2'd3
  } flsr_state_e;

  localparam logic [7:0] CMD_SR_READ  = 8'h70;
  localparam logic [7:0] CMD_SR_CLEAR = 8'h71;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RESUME   = 8'h30;

  typedef struct packed {
    logic sr_read;
    logic sr_clear;
    logic reset;
    logic suspend;
    logic resume;
  } flsr_cmd_t;

endpackage

// File: rtl/flsr_cmd_decode.sv
module flsr_cmd_decode
  import flsr_pkg::*;
(
  input  logic        cmd_we,
  input  logic [7:0]  cmd_code,
  input  flsr_state_e st,
  output flsr_cmd_t   cmd
);

  logic restricted;
  logic busy;

  always_comb begin
    restricted   = (st == ST_PROT) || (st == ST_ERR);
    busy         = (st == ST_BUSY);
    cmd.sr_read  = cmd_we && (cmd_code == CMD_SR_READ);
    cmd.sr_clear = cmd_we && (cmd_code == CMD_SR_CLEAR);
    cmd.reset    = cmd_we && (cmd_code == CMD_RESET);
    cmd.suspend  = cmd_we && !restricted && busy && (cmd_code == CMD_SUSPEND);
    cmd.resume   = cmd_we && !restricted && busy && (cmd_code == CMD_RESUME);
  end

endmodule

// File: rtl/flsr_prot_timer.sv
module flsr_prot_timer #(
  parameter int unsigned PROT_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(PROT_CYCLES + 1);
  localparam logic [CW-1:0] START = CW'(PROT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= START;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flsr_poll_gen.sv
module flsr_poll_gen #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          restart,
  input  logic          is_erase,
  input  logic          last_b7,
  input  logic          in_err,
  input  logic          abort_flag,
  output logic [DW-1:0] word
);

  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      tgl_q <= 1'b0;
    end else if (advance) begin
      tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    word    = '0;
    word[7] = !is_erase && !last_b7;
    word[6] = tgl_q;
    word[5] = in_err;
    word[3] = is_erase;
    word[2] = tgl_q;
    word[1] = in_err && abort_flag;
  end

endmodule

// File: rtl/flsr_status_unit.sv
module flsr_status_unit
  import flsr_pkg::*;
#(
  parameter int unsigned    DW          = 16,
  parameter int unsigned    AW          = 16,
  parameter int unsigned    PROT_CYCLES = 2000,
  parameter logic [DW-1:0]  STUB_WORD   = 'hA5C3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_code,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          op_start,
  input  logic          op_is_erase,
  input  logic          wb_last_bit7,
  input  logic          op_done,
  input  logic          ev_prog_fail,
  input  logic          ev_erase_fail,
  input  logic          ev_protect,
  input  logic          ev_wb_abort,
  output logic          ready_nbusy
);

  flsr_state_e st_q, st_n;
  logic [6:1]  sr_q, sr_n;
  logic        pend_q, pend_n;
  logic        erase_q, b7_q;
  logic        prot_load, prot_done;
  logic        err_any;
  logic        advance;
  logic [7:0]  sr_view;
  logic [DW-1:0] poll_word;
  flsr_cmd_t   cmd;

  flsr_cmd_decode u_dec (
    .cmd_we   (cmd_we),
    .cmd_code (cmd_code),
    .st       (st_q),
    .cmd      (cmd)
  );

  flsr_prot_timer #(.PROT_CYCLES(PROT_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (prot_load),
    .run     (st_q == ST_PROT),
    .expired (prot_done)
  );

  assign advance = rd_en && !pend_q && (st_q != ST_IDLE);

  flsr_poll_gen #(.DW(DW)) u_poll (
    .clk        (clk),
    .rst        (rst),
    .advance    (advance),
    .restart    (cmd.reset),
    .is_erase   (erase_q),
    .last_b7    (b7_q),
    .in_err     (st_q == ST_ERR),
    .abort_flag (sr_q[3]),
    .word       (poll_word)
  );

  assign err_any = ev_prog_fail || ev_erase_fail || ev_wb_abort;
  assign sr_view = {(st_q == ST_IDLE) || (st_q == ST_ERR), sr_q, 1'b0};

  always_comb begin
    st_n      = st_q;
    sr_n      = sr_q;
    pend_n    = pend_q;
    prot_load = 1'b0;
    if (rd_en && pend_q) pend_n = 1'b0;
    if (cmd.sr_read)     pend_n = 1'b1;
    if (cmd.sr_clear) begin
      sr_n[5:1] = '0;
      if (st_q == ST_ERR) st_n = ST_IDLE;
    end
    if (cmd.reset) begin
      sr_n   = '0;
      pend_n = 1'b0;
      if ((st_q == ST_BUSY) || (st_q == ST_ERR)) st_n = ST_IDLE;
    end
    if (cmd.suspend) begin
      if (erase_q) sr_n[6] = 1'b1;
      else         sr_n[2] = 1'b1;
    end
    if (cmd.resume) begin
      sr_n[6] = 1'b0;
      sr_n[2] = 1'b0;
    end
    case (st_q)
      ST_IDLE: if (op_start) st_n = ST_BUSY;
      ST_BUSY: begin
        if (!cmd.reset) begin
          if (err_any) begin
            st_n = ST_ERR;
            if (ev_prog_fail)  sr_n[4] = 1'b1;
            if (ev_erase_fail) sr_n[5] = 1'b1;
            if (ev_wb_abort)   sr_n[3] = 1'b1;
          end else if (ev_protect) begin
            st_n      = ST_PROT;
            sr_n[1]   = 1'b1;
            prot_load = 1'b1;
          end else if (op_done) begin
            st_n    = ST_IDLE;
            sr_n[6] = 1'b0;
            sr_n[2] = 1'b0;
          end
        end
      end
      ST_PROT: if (prot_done) st_n = ST_IDLE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      sr_q        <= '0;
      pend_q      <= 1'b0;
      erase_q     <= 1'b0;
      b7_q        <= 1'b0;
      ready_nbusy <= 1'b1;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      st_q        <= st_n;
      sr_q        <= sr_n;
      pend_q      <= pend_n;
      ready_nbusy <= (st_n == ST_IDLE);
      rd_valid    <= rd_en;
      if ((st_q == ST_IDLE) && op_start) begin
        erase_q <= op_is_erase;
        b7_q    <= wb_last_bit7;
      end
      if (rd_en) begin
        if (pend_q)                rd_data <= {{(DW-8){1'b0}}, sr_view};
        else if (st_q != ST_IDLE)  rd_data <= poll_word;
        else                       rd_data <= STUB_WORD ^ DW'(rd_addr);
      end
    end
  end

endmodule

// File: rtl/flsr_status_checker.sv
module flsr_status_checker
  import flsr_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned PROT_CYCLES = 2000
) (
  input logic          clk,
  input logic          rst,
  input flsr_state_e   st_q,
  input logic          pend_q,
  input logic          erase_q,
  input logic          cmd_we,
  input logic [7:0]    cmd_code,
  input logic          ev_prog_fail,
  input logic          ev_erase_fail,
  input logic          ev_wb_abort,
  input logic          rd_en,
  input logic          ready_nbusy,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data
);

  int unsigned win_q;
  logic clr_or_rst;
  logic poll_rd;

  assign clr_or_rst = cmd_we && ((cmd_code == CMD_SR_CLEAR) || (cmd_code == CMD_RESET));
  assign poll_rd    = rd_en && !pend_q && (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst)                 win_q <= 0;
    else if (st_q == ST_PROT) win_q <= win_q + 1;
    else                     win_q <= 0;
  end

  assert_fail_latches_R4: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_BUSY) && (ev_prog_fail || ev_erase_fail || ev_wb_abort) &&
     !(cmd_we && (cmd_code == CMD_RESET)))
    |=> ((st_q == ST_ERR) && !ready_nbusy));

  assert_err_holds_R5: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_ERR) && !clr_or_rst) |=> (st_q == ST_ERR));

  assert_poll_reserved_R3: assert property (@(posedge clk) disable iff (rst)
    poll_rd |=> (rd_valid && (rd_data[DW-1:8] == '0) && !rd_data[4] && !rd_data[0] &&
                 (rd_data[6] == rd_data[2])));

  assert_poll_erase_R3: assert property (@(posedge clk) disable iff (rst)
    (poll_rd && erase_q) |=> (rd_data[3] && !rd_data[7]));

  assert_poll_busy_noabort_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !pend_q && (st_q == ST_BUSY)) |=> (!rd_data[1] && !rd_data[5]));

  assert_prot_nofail_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !pend_q && (st_q == ST_PROT)) |=> !rd_data[5]);

  assert_prot_window_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PROT) |-> ((win_q < PROT_CYCLES) && !ready_nbusy));

  assert_prot_ends_R7: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_PROT) && (win_q == PROT_CYCLES - 1)) |=> (st_q == ST_IDLE));

  assert_sr_frame_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && pend_q) |=> (rd_valid && (rd_data[DW-1:8] == '0) && !rd_data[0]));

  assert_prot_invalid_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && pend_q && (st_q == ST_PROT)) |=> !rd_data[7]);

endmodule

bind flsr_status_unit flsr_status_checker #(.DW(DW), .PROT_CYCLES(PROT_CYCLES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .st_q          (st_q),
  .pend_q        (pend_q),
  .erase_q       (erase_q),
  .cmd_we        (cmd_we),
  .cmd_code      (cmd_code),
  .ev_prog_fail  (ev_prog_fail),
  .ev_erase_fail (ev_erase_fail),
  .ev_wb_abort   (ev_wb_abort),
  .rd_en         (rd_en),
  .ready_nbusy   (ready_nbusy),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data)
);

// File: tb/test_flsr_status_unit.sv
module test_flsr_status_unit;

  localparam int PROT = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = 16'h0000;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        op_start = 1'b0, op_is_erase = 1'b0, wb_last_bit7 = 1'b0, op_done = 1'b0;
  logic        ev_prog_fail = 1'b0, ev_erase_fail = 1'b0, ev_protect = 1'b0, ev_wb_abort = 1'b0;
  logic        ready_nbusy;

  flsr_status_unit #(.DW(16), .AW(16), .PROT_CYCLES(PROT), .STUB_WORD(16'hA5C3)) i_flsr_status_unit (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .op_start(op_start),
    .op_is_erase(op_is_erase), .wb_last_bit7(wb_last_bit7), .op_done(op_done),
    .ev_prog_fail(ev_prog_fail), .ev_erase_fail(ev_erase_fail), .ev_protect(ev_protect),
    .ev_wb_abort(ev_wb_abort), .ready_nbusy(ready_nbusy)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference: 0 idle, 1 busy, 2 protection window, 3 error
  int m_st = 0;
  int m_cnt = 0;
  logic [7:0] m_sr = 8'h00;
  bit m_pend = 0, m_tgl = 0, m_erase = 0, m_b7 = 0;
  logic e_val = 1'b0, e_rdy = 1'b1;
  logic [15:0] e_data = 16'h0, e_mask = 16'hFFFF;

  task automatic model_step();
    int s0 = m_st;
    bit rst_taken = 0;
    if (rd_en) begin
      e_val = 1'b1; e_mask = 16'hFFFF;
      if (m_pend) begin
        e_data = {8'h00, (s0 == 0 || s0 == 3), m_sr[6:1], 1'b0};
        if (s0 == 2) e_mask = 16'hFF80;
        m_pend = 0;
      end else if (s0 != 0) begin
        e_data = 16'h0;
        e_data[7] = m_erase ? 1'b0 : ~m_b7;
        e_data[6] = m_tgl; e_data[2] = m_tgl;
        e_data[5] = (s0 == 3);
        e_data[3] = m_erase;
        e_data[1] = (s0 == 3) && m_sr[3];
        m_tgl = ~m_tgl;
      end else begin
        e_data = 16'hA5C3 ^ rd_addr;
      end
    end else e_val = 1'b0;
    if (cmd_we && ((s0 <= 1) || cmd_code == 8'h70 || cmd_code == 8'h71 || cmd_code == 8'hF0)) begin
      case (cmd_code)
        8'h70: m_pend = 1;
        8'h71: begin m_sr[5:1] = 0; if (s0 == 3) m_st = 0; end
        8'hF0: begin m_sr = 0; m_pend = 0; m_tgl = 0; rst_taken = 1;
                     if (s0 == 1 || s0 == 3) m_st = 0; end
        8'hB0: if (s0 == 1) begin if (m_erase) m_sr[6] = 1; else m_sr[2] = 1; end
        8'h30: if (s0 == 1) begin m_sr[6] = 0; m_sr[2] = 0; end
        default: ;
      endcase
    end
    if (s0 == 1 && !rst_taken) begin
      if (ev_prog_fail || ev_erase_fail || ev_wb_abort) begin
        m_st = 3;
        if (ev_prog_fail)  m_sr[4] = 1;
        if (ev_erase_fail) m_sr[5] = 1;
        if (ev_wb_abort)   m_sr[3] = 1;
      end else if (ev_protect) begin
        m_st = 2; m_sr[1] = 1; m_cnt = PROT - 1;
      end else if (op_done) begin
        m_st = 0; m_sr[6] = 0; m_sr[2] = 0;
      end
    end
    if (s0 == 2) begin
      if (m_cnt == 0) m_st = 0; else m_cnt = m_cnt - 1;
    end
    if (s0 == 0 && op_start) begin
      m_st = 1; m_erase = op_is_erase; m_b7 = wb_last_bit7;
    end
    e_rdy = (m_st == 0);
  endtask

  task automatic check();
    vectors++;
    if (ready_nbusy !== e_rdy) begin
      miscompares++;
      $display("FAIL %s ready_nbusy actual=%b expected=%b at %0t", cur_req, ready_nbusy, e_rdy, $time);
    end
    if (rd_valid !== e_val) begin
      miscompares++;
      $display("FAIL %s rd_valid actual=%b expected=%b at %0t", cur_req, rd_valid, e_val, $time);
    end else if (e_val && ((rd_data & e_mask) !== (e_data & e_mask))) begin
      miscompares++;
      $display("FAIL %s rd_data actual=%h expected=%h mask=%h at %0t", cur_req, rd_data, e_data, e_mask, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check();
    cmd_we = 0; rd_en = 0; op_start = 0; op_done = 0;
    ev_prog_fail = 0; ev_erase_fail = 0; ev_protect = 0; ev_wb_abort = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic cmd(logic [7:0] c);
    cmd_we = 1; cmd_code = c; cyc();
  endtask
  task automatic rd(logic [15:0] a);
    rd_en = 1; rd_addr = a; cyc();
  endtask
  task automatic sr_rd();
    cmd(8'h70); rd(16'h1234);
  endtask
  task automatic start(bit er, bit b7);
    op_start = 1; op_is_erase = er; wb_last_bit7 = b7; cyc();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired during %s", cur_req);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cur_req = "R1";
    check();                      // R1 reset state
    rd(16'h0000); rd(16'h00FF); rd(16'hFFFF);
    sr_rd(); rd(16'h0042);        // R1 status 0x80, then array again
    // R2, R3: program with polling reads
    cur_req = "R2"; start(0, 1); op_start = 1; cyc();   // R2 second start ignored
    cur_req = "R3"; rd(16'h0001); rd(16'h7777); rd(16'h0003);
    cur_req = "R12"; cmd(8'hB0); sr_rd(); cmd(8'h30); sr_rd();
    cmd(8'hB0); cur_req = "R2"; op_done = 1; cyc(); sr_rd(); rd(16'h0005);
    // R4, R5, R6: erase with suspend, then erase failure
    cur_req = "R4"; start(1, 0); cmd(8'hB0); rd(16'h0);
    ev_erase_fail = 1; cyc(); sr_rd(); rd(16'h9); rd(16'hA);
    cur_req = "R6"; cmd(8'h30); cmd(8'h55); start(0, 0); sr_rd(); rd(16'h2);
    cur_req = "R13"; ev_protect = 1; ev_prog_fail = 1; op_done = 1; cyc(); sr_rd();
    cur_req = "R5"; idle(10); rd(16'h3);
    cur_req = "R10"; cmd(8'h71); sr_rd(); rd(16'h0010);
    // R4, R11: program write-buffer abort, cleared by reset
    cur_req = "R4"; start(0, 0); rd(16'h1); ev_wb_abort = 1; cyc();
    rd(16'h2); sr_rd(); cmd(8'h70);
    cur_req = "R11"; cmd(8'hF0); rd(16'h0020); sr_rd();
    // R4: program failure
    cur_req = "R4"; start(0, 1); ev_prog_fail = 1; cyc(); sr_rd(); cmd(8'h71);
    // R13: failure over protection over done
    cur_req = "R13"; start(1, 1); ev_prog_fail = 1; ev_protect = 1; cyc(); sr_rd(); cmd(8'hF0);
    start(0, 0); ev_protect = 1; op_done = 1; cyc();
    // R7, R8, R10, R11: protection window
    cur_req = "R8"; sr_rd(); rd(16'h4);
    cur_req = "R7"; rd(16'h5);
    cur_req = "R6"; cmd(8'hB0); op_start = 1; cyc(); ev_prog_fail = 1; cyc();
    cur_req = "R10"; cmd(8'h71);
    cur_req = "R11"; cmd(8'hF0);
    cur_req = "R7"; idle(PROT); sr_rd(); rd(16'h0030);
    // R11: reset aborts a busy overlay, toggle restarts
    cur_req = "R11"; start(1, 0); rd(16'h1); cmd(8'hF0); rd(16'h0040);
    start(1, 0); rd(16'h1); rd(16'h2); op_done = 1; cyc();
    // R9: status read in busy shows not-valid, then reverts to polling
    cur_req = "R9"; start(0, 0); sr_rd(); rd(16'h3); op_done = 1; cyc(); sr_rd();
    done = 1;
    summary();
  end

endmodule